// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose register storage of a 32-bit processor core whose register set is partly duplicated per operating mode. A register is named by a 4-bit logical number, and the core's current 5-bit mode field decides which physical copy that name reaches. The fast-interrupt mode has private copies of registers 8 through 14. The interrupt, supervisor, abort and undefined modes each have private copies of only the stack pointer (13) and the link register (14). User and system modes share the base set. Each of the five exception modes also owns one saved-status word.

There are two combinational read ports and one write port for general registers. A separate port reads and writes the saved-status word of the current mode. A dedicated exception-entry port writes the link register and the saved-status word of a target exception mode in a single cycle. Register 15 is the program counter and is not stored here: reads of it return the `pc_in` input, and a write to it is passed out as a branch request. The status register itself and instruction decode live elsewhere.

Top module: `banked_regfile`

## Requirements
- R1: After reset every stored register and every saved-status word reads as zero, and `branch_req` is low.
- R2: Registers 0 to 7 are one physical set that every mode reads and writes.
- R3: Mode encodings are user 10000, fast-interrupt 10001, interrupt 10010, supervisor 10011, abort 10111, undefined 11011 and system 11111. User and system modes reach the same registers. Any other encoding behaves as user mode.
- R4: In fast-interrupt mode, registers 8 to 14 are private copies that no other mode can see or change.
- R5: Interrupt, supervisor, abort and undefined modes each have private registers 13 and 14. Their registers 8 to 12 are the user-mode ones.
- R6: Reading register 15 on either read port returns `pc_in`. A write to register 15 stores nothing; in the same cycle it drives `branch_req` high and `branch_target` equal to `wr_data`. `branch_req` is low whenever `wr_en` is low.
- R7: Each exception mode has its own saved-status word, written through `ss_wr_en` and read on `ss_rd_data`. In user, system or an unrecognised mode, `ss_rd_data` is zero and `ss_wr_en` has no effect.
- R8: With `exc_en` high, `exc_link` is written into register 14 of the mode given by `exc_mode`, and `exc_status` into that mode's saved-status word. Both values are readable after the next clock edge. If `exc_mode` is not one of the five exception modes, the port writes nothing.
- R9: A register or saved-status word written in a cycle is returned by a read of that same physical location in that same cycle.
- R10: When the exception-entry port and a general or saved-status write target the same location in the same cycle, the exception-entry value is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 5 | Current operating-mode field |
| rd_a_idx | input | 4 | Logical register, read port A |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Logical register, read port B |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | Logical register to write |
| wr_data | input | 32 | Write data |
| pc_in | input | 32 | Current program counter, returned for register 15 |
| branch_req | output | 1 | A write to register 15 is in progress |
| branch_target | output | 32 | New program counter for that write |
| ss_wr_en | input | 1 | Saved-status write enable, current mode |
| ss_wr_data | input | 32 | Saved-status write data |
| ss_rd_data | output | 32 | Saved-status word of the current mode |
| exc_en | input | 1 | Exception-entry write strobe |
| exc_mode | input | 5 | Mode being entered |
| exc_link | input | 32 | Return address for the new mode's register 14 |
| exc_status | input | 32 | Status word to save for the new mode |

## Verification
Reads, the register-15 substitution, the branch request and forwarding are all combinational, so those results are due in the same cycle as the stimulus. Writes from either write path become visible in storage after exactly one rising edge. The bench changes inputs on the falling edge and samples one time unit later. A stored value is therefore read in a cycle after the write's edge, and a forwarded value before it, so no check depends on the order of events at a clock edge. Sweeps write a distinct value to every logical register in every mode, including one unrecognised encoding, and then read back the whole grid. The expected value for each cell comes from a sharing model in the bench.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

    localparam int IDX_W      = 4;
    localparam int MODE_W     = 5;
    localparam int PC_IDX     = 15;
    localparam int SP_IDX     = 13;
    localparam int LINK_IDX   = 14;
    localparam int FAST_LO    = 8;
    localparam int BASE_REGS  = 15;
    localparam int FAST_REGS  = LINK_IDX - FAST_LO + 1;
    localparam int PAIR_MODES = 4;
    localparam int PAIR_REGS  = LINK_IDX - SP_IDX + 1;
    localparam int FAST_BASE  = BASE_REGS;
    localparam int PAIR_BASE  = FAST_BASE + FAST_REGS;
    localparam int NUM_PHYS   = PAIR_BASE + PAIR_MODES * PAIR_REGS;
    localparam int PHYS_W     = $clog2(NUM_PHYS);
    localparam int NUM_SS     = PAIR_MODES + 1;
    localparam int SS_W       = $clog2(NUM_SS);

    localparam logic [MODE_W-1:0] MD_USER = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FAST = 5'b10001;
    localparam logic [MODE_W-1:0] MD_INTR = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SUPV = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABRT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UNDF = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYST = 5'b11111;

    typedef enum logic [2:0] {
        BK_BASE = 3'd0,
        BK_FAST = 3'd1,
        BK_INTR = 3'd2,
        BK_SUPV = 3'd3,
        BK_ABRT = 3'd4,
        BK_UNDF = 3'd5
    } bank_e;

endpackage

// File: rtl/mode_decode.sv
module mode_decode
    import banked_rf_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output bank_e             bank_o,
    output logic              ss_ok_o,
    output logic [SS_W-1:0]   ss_slot_o
);

    always_comb begin
        unique case (mode_i)
            MD_FAST: bank_o = BK_FAST;
            MD_INTR: bank_o = BK_INTR;
            MD_SUPV: bank_o = BK_SUPV;
            MD_ABRT: bank_o = BK_ABRT;
            MD_UNDF: bank_o = BK_UNDF;
            default: bank_o = BK_BASE;
        endcase
    end

    // Saved-status slots are numbered from the fast bank upward.
    assign ss_ok_o   = (bank_o != BK_BASE);
    assign ss_slot_o = ss_ok_o ? SS_W'(int'(bank_o) - 1) : '0;

endmodule

// File: rtl/reg_locator.sv
module reg_locator
    import banked_rf_pkg::*;
(
    input  logic [IDX_W-1:0]  idx_i,
    input  bank_e             bank_i,
    output logic [PHYS_W-1:0] phys_o,
    output logic              is_pc_o
);

    int lidx;
    int bnum;
    int slot;

    always_comb begin
        lidx    = int'(idx_i);
        bnum    = int'(bank_i);
        is_pc_o = (lidx == PC_IDX);
        slot    = lidx;
        if (bank_i == BK_FAST && lidx >= FAST_LO && lidx <= LINK_IDX) begin
            slot = FAST_BASE + (lidx - FAST_LO);
        end else if (bnum >= int'(BK_INTR) && lidx >= SP_IDX && lidx <= LINK_IDX) begin
            slot = PAIR_BASE + PAIR_REGS * (bnum - int'(BK_INTR)) + (lidx - SP_IDX);
        end else if (is_pc_o) begin
            slot = 0;
        end
        phys_o = PHYS_W'(slot);
    end

endmodule

// File: rtl/regbank_store.sv
module regbank_store
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              g_we,
    input  logic [PHYS_W-1:0] g_addr,
    input  logic [DATA_W-1:0] g_data,
    input  logic              l_we,
    input  logic [PHYS_W-1:0] l_addr,
    input  logic [DATA_W-1:0] l_data,
    input  logic [PHYS_W-1:0] ra_addr,
    output logic [DATA_W-1:0] ra_data,
    input  logic [PHYS_W-1:0] rb_addr,
    output logic [DATA_W-1:0] rb_data,
    input  logic              s_we,
    input  logic [SS_W-1:0]   s_slot,
    input  logic [DATA_W-1:0] s_data,
    input  logic              e_we,
    input  logic [SS_W-1:0]   e_slot,
    input  logic [DATA_W-1:0] e_data,
    input  logic [SS_W-1:0]   s_rd_slot,
    output logic [DATA_W-1:0] s_rd_data
);

    logic [DATA_W-1:0] cells [NUM_PHYS];
    logic [DATA_W-1:0] saved [NUM_SS];

    for (genvar g = 0; g < NUM_PHYS; g++) begin : g_cell
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (l_we && l_addr == PHYS_W'(g)) begin
                q <= l_data;
            end else if (g_we && g_addr == PHYS_W'(g)) begin
                q <= g_data;
            end
        end
        assign cells[g] = q;
    end

    for (genvar s = 0; s < NUM_SS; s++) begin : g_saved
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (e_we && e_slot == SS_W'(s)) begin
                q <= e_data;
            end else if (s_we && s_slot == SS_W'(s)) begin
                q <= s_data;
            end
        end
        assign saved[s] = q;
    end

    function automatic logic [DATA_W-1:0] gpr_view(input logic [PHYS_W-1:0] a);
        if (l_we && l_addr == a)      return l_data;
        else if (g_we && g_addr == a) return g_data;
        else                          return cells[a];
    endfunction

    assign ra_data = gpr_view(ra_addr);
    assign rb_data = gpr_view(rb_addr);

    always_comb begin
        if (e_we && e_slot == s_rd_slot)      s_rd_data = e_data;
        else if (s_we && s_slot == s_rd_slot) s_rd_data = s_data;
        else                                  s_rd_data = saved[s_rd_slot];
    end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import banked_rf_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        mode,
    input  logic [3:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [3:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [3:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] pc_in,
    output logic              branch_req,
    output logic [DATA_W-1:0] branch_target,
    input  logic              ss_wr_en,
    input  logic [DATA_W-1:0] ss_wr_data,
    output logic [DATA_W-1:0] ss_rd_data,
    input  logic              exc_en,
    input  logic [4:0]        exc_mode,
    input  logic [DATA_W-1:0] exc_link,
    input  logic [DATA_W-1:0] exc_status
);

    bank_e             cur_bank, exc_bank;
    logic              cur_ss_ok, exc_ss_ok;
    logic [SS_W-1:0]   cur_slot, exc_slot;
    logic [PHYS_W-1:0] a_phys, b_phys, w_phys, l_phys;
    logic              a_pc, b_pc, w_pc, l_pc;
    logic [DATA_W-1:0] a_raw, b_raw, ss_raw;
    logic              exc_go;

    mode_decode u_cur_dec (
        .mode_i   (mode),
        .bank_o   (cur_bank),
        .ss_ok_o  (cur_ss_ok),
        .ss_slot_o(cur_slot)
    );

    mode_decode u_exc_dec (
        .mode_i   (exc_mode),
        .bank_o   (exc_bank),
        .ss_ok_o  (exc_ss_ok),
        .ss_slot_o(exc_slot)
    );

    reg_locator u_loc_a (.idx_i(rd_a_idx), .bank_i(cur_bank), .phys_o(a_phys), .is_pc_o(a_pc));
    reg_locator u_loc_b (.idx_i(rd_b_idx), .bank_i(cur_bank), .phys_o(b_phys), .is_pc_o(b_pc));
    reg_locator u_loc_w (.idx_i(wr_idx),   .bank_i(cur_bank), .phys_o(w_phys), .is_pc_o(w_pc));
    reg_locator u_loc_l (.idx_i(IDX_W'(LINK_IDX)), .bank_i(exc_bank), .phys_o(l_phys), .is_pc_o(l_pc));

    assign exc_go = exc_en && exc_ss_ok && !l_pc;

    regbank_store #(.DATA_W(DATA_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .g_we     (wr_en && !w_pc),
        .g_addr   (w_phys),
        .g_data   (wr_data),
        .l_we     (exc_go),
        .l_addr   (l_phys),
        .l_data   (exc_link),
        .ra_addr  (a_phys),
        .ra_data  (a_raw),
        .rb_addr  (b_phys),
        .rb_data  (b_raw),
        .s_we     (ss_wr_en && cur_ss_ok),
        .s_slot   (cur_slot),
        .s_data   (ss_wr_data),
        .e_we     (exc_go),
        .e_slot   (exc_slot),
        .e_data   (exc_status),
        .s_rd_slot(cur_slot),
        .s_rd_data(ss_raw)
    );

    assign rd_a_data     = a_pc ? pc_in : a_raw;
    assign rd_b_data     = b_pc ? pc_in : b_raw;
    assign ss_rd_data    = cur_ss_ok ? ss_raw : '0;
    assign branch_req    = wr_en && w_pc;
    assign branch_target = wr_data;

endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        mode,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [3:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] pc_in,
    input logic              branch_req,
    input logic [DATA_W-1:0] branch_target,
    input logic [DATA_W-1:0] ss_rd_data,
    input logic              exc_en
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R6
    pc_read_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_idx == 4'd15 |-> rd_a_data == pc_in);

    // R6
    pc_read_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_idx == 4'd15 |-> rd_b_data == pc_in);

    // R6
    branch_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 4'd15) |-> (branch_req && branch_target == wr_data));

    // R6
    no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> !branch_req);

    // R7
    ss_base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 5'b10000 || mode == 5'b11111) |-> ss_rd_data == '0);

    // R9
    fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !exc_en && wr_idx == rd_a_idx && wr_idx != 4'd15) |-> rd_a_data == wr_data);

    // R2
    low_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(wr_en) && $past(wr_idx) < 4'd8 && !wr_en
         && rd_a_idx == $past(wr_idx)) |-> rd_a_data == $past(wr_data));

endmodule

bind banked_regfile banked_regfile_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .rd_b_idx     (rd_b_idx),
    .rd_b_data    (rd_b_data),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .pc_in        (pc_in),
    .branch_req   (branch_req),
    .branch_target(branch_target),
    .ss_rd_data   (ss_rd_data),
    .exc_en       (exc_en)
);

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  mode = 5'b10000;
    logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [31:0] rd_a_data, rd_b_data, branch_target, ss_rd_data;
    logic        wr_en = 1'b0, ss_wr_en = 1'b0, exc_en = 1'b0, branch_req;
    logic [31:0] wr_data = '0, pc_in = '0, ss_wr_data = '0, exc_link = '0, exc_status = '0;
    logic [4:0]  exc_mode = 5'b10000;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [0:699];
    logic [31:0] ss_model [0:7];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile u_dut (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .pc_in(pc_in), .branch_req(branch_req), .branch_target(branch_target),
        .ss_wr_en(ss_wr_en), .ss_wr_data(ss_wr_data), .ss_rd_data(ss_rd_data),
        .exc_en(exc_en), .exc_mode(exc_mode), .exc_link(exc_link), .exc_status(exc_status)
    );

    // Mode table: 0 user, 1 fast, 2 interrupt, 3 supervisor, 4 abort, 5 undefined, 6 system, 7 unrecognised.
    function automatic logic [4:0] md(input int i);
        case (i)
            0: return 5'b10000;
            1: return 5'b10001;
            2: return 5'b10010;
            3: return 5'b10011;
            4: return 5'b10111;
            5: return 5'b11011;
            6: return 5'b11111;
            default: return 5'b10100;
        endcase
    endfunction

    // Storage identity from R2..R5: shared unless the mode owns a private copy.
    function automatic int cell_key(input int mi, input int idx);
        int b;
        b = (mi >= 6) ? 0 : mi;
        if (b == 1 && idx >= 8) return 100 + idx;
        if (b >= 2 && idx >= 13) return 100 * b + idx;
        return idx;
    endfunction

    function automatic string tag_of(input int mi, input int idx);
        if (idx < 8)  return "R2";
        if (mi >= 6)  return "R3";
        if (mi == 1)  return "R4";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input int mi, input int idx, input logic [31:0] d);
        @(negedge clk);
        mode = md(mi); wr_idx = 4'(idx); wr_data = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 700; i++) model[i] = '0;
        for (int i = 0; i < 8; i++) ss_model[i] = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents
        for (int mi = 0; mi < 8; mi++) begin
            @(negedge clk);
            mode = md(mi); rd_a_idx = 4'd14; rd_b_idx = 4'd3; #1;
            chk("R1", rd_a_data, 32'h0);
            chk("R1", rd_b_data, 32'h0);
            chk("R1", ss_rd_data, 32'h0);
            chk("R1", {31'h0, branch_req}, 32'h0);
        end

        // Sweep: a distinct value into every logical register in every mode.
        for (int mi = 0; mi < 8; mi++) begin
            for (int idx = 0; idx < 16; idx++) begin
                logic [31:0] v;
                v = 32'hA500_0000 | (mi << 8) | idx;
                if (idx == 15) begin
                    @(negedge clk);
                    mode = md(mi); wr_idx = 4'd15; wr_data = v; wr_en = 1'b1; #1;
                    chk("R6", {31'h0, branch_req}, 32'h1);
                    chk("R6", branch_target, v);
                    @(posedge clk); #1;
                    wr_en = 1'b0;
                end else begin
                    do_write(mi, idx, v);
                    model[cell_key(mi, idx)] = v;
                end
            end
        end

        // Read back the whole grid on both ports.
        pc_in = 32'h0000_8000;
        for (int mi = 0; mi < 8; mi++) begin
            for (int idx = 0; idx < 16; idx++) begin
                @(negedge clk);
                mode = md(mi); rd_a_idx = 4'(idx); rd_b_idx = 4'(15 - idx);
                pc_in = pc_in + 32'h4; #1;
                if (idx == 15) chk("R6", rd_a_data, pc_in);
                else           chk(tag_of(mi, idx), rd_a_data, model[cell_key(mi, idx)]);
                if (idx == 0)  chk("R6", rd_b_data, pc_in);
                else           chk(tag_of(mi, 15 - idx), rd_b_data, model[cell_key(mi, 15 - idx)]);
            end
        end

        // R7: saved-status port in every mode.
        for (int mi = 0; mi < 8; mi++) begin
            @(negedge clk);
            mode = md(mi); ss_wr_data = 32'h5500_0000 | mi; ss_wr_en = 1'b1;
            @(posedge clk); #1;
            ss_wr_en = 1'b0;
            if (mi >= 1 && mi <= 5) ss_model[mi] = 32'h5500_0000 | mi;
        end
        for (int mi = 0; mi < 8; mi++) begin
            @(negedge clk);
            mode = md(mi); #1;
            chk("R7", ss_rd_data, ss_model[mi]);
        end

        // R8: exception entry into each exception mode, issued from user mode.
        for (int mi = 1; mi <= 5; mi++) begin
            @(negedge clk);
            mode = md(0); exc_mode = md(mi); exc_en = 1'b1;
            exc_link = 32'hE000_0000 | mi; exc_status = 32'h0000_00D0 | mi;
            @(posedge clk); #1;
            exc_en = 1'b0;
            model[cell_key(mi, 14)] = 32'hE000_0000 | mi;
            ss_model[mi] = 32'h0000_00D0 | mi;
        end
        for (int mi = 0; mi < 8; mi++) begin
            @(negedge clk);
            mode = md(mi); rd_a_idx = 4'd14; rd_b_idx = 4'd13; #1;
            chk("R8", rd_a_data, model[cell_key(mi, 14)]);
            chk("R8", rd_b_data, model[cell_key(mi, 13)]);
            chk("R8", ss_rd_data, ss_model[mi]);
        end
        // R8: entry naming user, system or an unknown mode writes nothing.
        for (int mi = 6; mi < 9; mi++) begin
            @(negedge clk);
            exc_mode = (mi == 8) ? md(0) : md(mi); exc_en = 1'b1;
            exc_link = 32'hBAD0_0000; exc_status = 32'hBAD0_0001;
            @(posedge clk); #1;
            exc_en = 1'b0;
        end
        @(negedge clk);
        mode = md(0); rd_a_idx = 4'd14; #1;
        chk("R8", rd_a_data, model[cell_key(0, 14)]);
        chk("R8", ss_rd_data, 32'h0);

        // R9: same-cycle forwarding.
        @(negedge clk);
        mode = md(1); wr_idx = 4'd9; wr_data = 32'hF00D_0009; wr_en = 1'b1;
        rd_a_idx = 4'd9; rd_b_idx = 4'd9; #1;
        chk("R9", rd_a_data, 32'hF00D_0009);
        chk("R9", rd_b_data, 32'hF00D_0009);
        @(posedge clk); #1; wr_en = 1'b0;
        @(negedge clk);
        mode = md(3); ss_wr_data = 32'h0000_5E53; ss_wr_en = 1'b1; #1;
        chk("R9", ss_rd_data, 32'h0000_5E53);
        @(posedge clk); #1; ss_wr_en = 1'b0;
        @(negedge clk);
        mode = md(2); exc_mode = md(2); exc_en = 1'b1;
        exc_link = 32'h1111_2222; exc_status = 32'h3333_4444; rd_b_idx = 4'd14; #1;
        chk("R9", rd_b_data, 32'h1111_2222);
        chk("R9", ss_rd_data, 32'h3333_4444);
        @(posedge clk); #1; exc_en = 1'b0;

        // R10: both write paths on the same location in one cycle.
        @(negedge clk);
        mode = md(4); wr_idx = 4'd14; wr_data = 32'hAAAA_0001; wr_en = 1'b1;
        ss_wr_data = 32'hAAAA_0002; ss_wr_en = 1'b1;
        exc_mode = md(4); exc_link = 32'hBBBB_0001; exc_status = 32'hBBBB_0002; exc_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0; ss_wr_en = 1'b0; exc_en = 1'b0;
        @(negedge clk);
        mode = md(4); rd_a_idx = 4'd14; #1;
        chk("R10", rd_a_data, 32'hBBBB_0001);
        chk("R10", ss_rd_data, 32'hBBBB_0002);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule